// File: doc/BRIEF.md
# Two-stage SCL period divider

This block produces the timing strobes that an I2C master sequencer uses to shape SCL. A first stage divides the peripheral clock by a small prescale value plus one, which gives an internal tick. A second stage counts those ticks to form one SCL period. The period is a fixed base of 20 ticks, plus 8 ticks for each step of a coarse divider field, plus a compensation count. The compensation count covers the bus rise time, the fall time and the internal delay, expressed in internal ticks.

Software writes one packed divider word. The prescale field sits at the bottom, with a width that is a build parameter of 2 or 3 bits. The coarse field sits directly above it. The compensation count comes from a separate small input. While the enable input is held high, the block runs back-to-back periods. Each period is a low phase followed by a high phase, and each phase boundary is marked with a one-cycle strobe. New divider values are only picked up at a period boundary, so a period in flight is never distorted.

Top module: `scl_div`

## Requirements
- R1: With prescale field P, every internal tick spans P+1 peripheral clocks, so one SCL period spans (P+1)·N peripheral clocks.
- R2: One SCL period spans N = 20 + 8·C + K internal ticks, where C is the coarse field and K is the compensation input.
- R3: Each period opens with a low phase of ceil(N/2) ticks, followed by a high phase of floor(N/2) ticks. highStrobe pulses in the cycle the high phase begins, with sclLevel 1.
- R4: divReg bits [1:0] hold P and bits [7:2] hold C (default 2-bit prescale field). C spans 0 to 63, and C = 63 gives N = 524 + K.
- R5: In the cycle after enable is first sampled high, lowStrobe is 1 and sclLevel is 0. No periodTick accompanies this first low strobe.
- R6: At the end of each completed period, periodTick and lowStrobe pulse together in the same cycle and sclLevel returns to 0.
- R7: A divReg or compCount change made during a period leaves that period's length unchanged. The change takes effect from the next period.
- R8: During reset, and in the cycle after enable is sampled low, all strobes are 0 and sclLevel is 1.
- R9: After a disable, raising enable again starts a fresh low phase with full length, using the values present at that moment.
- R10: The compensation input K adds exactly K ticks to the period, for K up to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | peripheral clock |
| rst_n | input | 1 | asynchronous active-low reset |
| enable | input | 1 | run the divider while high |
| divReg | input | CDF_W+SCGD_W | packed divider word, prescale field in the low bits |
| compCount | input | COMP_W | rise/fall compensation ticks |
| sclLevel | output | 1 | current SCL phase, 0 low, 1 high (1 when idle) |
| highStrobe | output | 1 | one-cycle pulse at the start of each high phase |
| lowStrobe | output | 1 | one-cycle pulse at the start of each low phase |
| periodTick | output | 1 | one-cycle pulse when a period completes |

## Verification
Two events can land on the same edge: a period boundary, and the adoption of new divider values. The bench rewrites divReg and compCount partway through a low phase. A reference model, which counts peripheral clocks from the start of each period, must then show that the old length finishes intact and that the next period already has the new length. A second coincidence is a disable arriving in the same cycle as a phase boundary. The model judges this cycle by cycle: idle must win.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clearCnt;  // hold both counters at zero
    logic loadCfg;   // capture divider fields
    logic stepPer;   // advance the tick counter
    logic wrapPer;   // restart the tick counter
  } sclCtl_t;
endpackage

// File: rtl/scl_div_datapath.sv
module scl_div_datapath
  import scl_div_pkg::*;
#(
  parameter int CDF_W  = 2,
  parameter int SCGD_W = 6,
  parameter int COMP_W = 5,
  parameter int BASE   = 20,
  parameter int STEP   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  sclCtl_t                  ctl,
  input  logic [CDF_W+SCGD_W-1:0]  divReg,
  input  logic [COMP_W-1:0]        compCount,
  output logic                     ickTick,
  output logic                     atHalf,
  output logic                     atEnd
);
  localparam int MAX_N = BASE + STEP * ((1 << SCGD_W) - 1) + ((1 << COMP_W) - 1);
  localparam int PER_W = $clog2(MAX_N + 2);

  logic [CDF_W-1:0]  cdfAct;
  logic [SCGD_W-1:0] scgdAct;
  logic [COMP_W-1:0] compAct;
  logic [CDF_W-1:0]  preCnt;
  logic [PER_W-1:0]  perCnt;
  logic [PER_W-1:0]  periodLen;
  logic [PER_W-1:0]  lowLen;

  assign periodLen = PER_W'(BASE) + PER_W'(scgdAct) * PER_W'(STEP) + PER_W'(compAct);
  assign lowLen    = (periodLen + PER_W'(1)) >> 1;
  assign ickTick   = (preCnt == cdfAct);
  assign atEnd     = (perCnt == periodLen - PER_W'(1));
  assign atHalf    = (perCnt == lowLen - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cdfAct  <= '0;
      scgdAct <= '0;
      compAct <= '0;
    end else if (ctl.loadCfg) begin
      cdfAct  <= divReg[CDF_W-1:0];
      scgdAct <= divReg[CDF_W+SCGD_W-1:CDF_W];
      compAct <= compCount;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
      perCnt <= '0;
    end else if (ctl.clearCnt) begin
      preCnt <= '0;
      perCnt <= '0;
    end else begin
      preCnt <= ickTick ? '0 : preCnt + CDF_W'(1);
      if (ctl.wrapPer)      perCnt <= '0;
      else if (ctl.stepPer) perCnt <= perCnt + PER_W'(1);
    end
  end
endmodule

// File: rtl/scl_div_ctrl.sv
module scl_div_ctrl
  import scl_div_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  logic    ickTick,
  input  logic    atHalf,
  input  logic    atEnd,
  output sclCtl_t ctl,
  output logic    sclLevel,
  output logic    highStrobe,
  output logic    lowStrobe,
  output logic    periodTick
);
  logic running;
  logic starting;
  logic boundary;
  logic midPoint;

  assign starting = enable && !running;
  assign boundary = enable && running && ickTick && atEnd;
  assign midPoint = enable && running && ickTick && atHalf && !atEnd;

  always_comb begin
    ctl          = '0;
    ctl.clearCnt = !enable || !running;
    ctl.loadCfg  = starting || boundary;
    ctl.stepPer  = enable && running && ickTick && !atEnd;
    ctl.wrapPer  = boundary;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      sclLevel   <= 1'b1;
      highStrobe <= 1'b0;
      lowStrobe  <= 1'b0;
      periodTick <= 1'b0;
    end else begin
      running    <= enable;
      highStrobe <= midPoint;
      lowStrobe  <= starting || boundary;
      periodTick <= boundary;
      if (!enable)                   sclLevel <= 1'b1;
      else if (starting || boundary) sclLevel <= 1'b0;
      else if (midPoint)             sclLevel <= 1'b1;
    end
  end
endmodule

// File: rtl/scl_div.sv
module scl_div
  import scl_div_pkg::*;
#(
  parameter int CDF_W  = 2,
  parameter int SCGD_W = 6,
  parameter int COMP_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [CDF_W+SCGD_W-1:0] divReg,
  input  logic [COMP_W-1:0]       compCount,
  output logic                    sclLevel,
  output logic                    highStrobe,
  output logic                    lowStrobe,
  output logic                    periodTick
);
  sclCtl_t ctl;
  logic ickTick;
  logic atHalf;
  logic atEnd;

  scl_div_datapath #(
    .CDF_W(CDF_W), .SCGD_W(SCGD_W), .COMP_W(COMP_W), .BASE(20), .STEP(8)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .divReg(divReg), .compCount(compCount),
    .ickTick(ickTick), .atHalf(atHalf), .atEnd(atEnd)
  );

  scl_div_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ickTick(ickTick),
    .atHalf(atHalf), .atEnd(atEnd), .ctl(ctl), .sclLevel(sclLevel),
    .highStrobe(highStrobe), .lowStrobe(lowStrobe), .periodTick(periodTick)
  );
endmodule

// File: rtl/scl_div_chk.sv
module scl_div_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic sclLevel,
  input logic highStrobe,
  input logic lowStrobe,
  input logic periodTick
);
  // R6
  tick_with_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periodTick |-> lowStrobe && !sclLevel);

  // R3
  high_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    highStrobe |-> sclLevel && !lowStrobe);

  // R8
  idle_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !highStrobe && !lowStrobe && !periodTick && sclLevel);

  // R5
  first_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable ##1 enable |=> lowStrobe && !periodTick && !sclLevel);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({highStrobe, lowStrobe}));
endmodule

bind scl_div scl_div_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sclLevel(sclLevel),
  .highStrobe(highStrobe), .lowStrobe(lowStrobe), .periodTick(periodTick)
);

// File: tb/scl_div_tb.sv
module scl_div_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [7:0] divReg = '0;
  logic [4:0] compCount = '0;
  logic sclLevel, highStrobe, lowStrobe, periodTick;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  string reqTag = "R8";

  always #2 clk = ~clk;

  scl_div u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .divReg(divReg), .compCount(compCount),
    .sclLevel(sclLevel), .highStrobe(highStrobe), .lowStrobe(lowStrobe), .periodTick(periodTick)
  );

  // behavioural reference: one clock counter per period
  int mRun = 0, mCnt = 0, mD = 1, mN = 20, mL = 10;
  int eLvl = 1, eHigh = 0, eLow = 0, eTick = 0;

  function automatic void loadModel();
    mD = int'(divReg[1:0]) + 1;
    mN = 20 + 8 * int'(divReg[7:2]) + int'(compCount);
    mL = (mN + 1) / 2;
  endfunction

  always @(posedge clk) begin
    eHigh = 0; eLow = 0; eTick = 0;
    if (!rst_n || !enable) begin
      mRun = 0; eLvl = 1;
    end else if (mRun == 0) begin
      mRun = 1; mCnt = 0; loadModel(); eLow = 1; eLvl = 0;
    end else begin
      mCnt++;
      if (mCnt == mD * mN) begin
        mCnt = 0; loadModel(); eLow = 1; eTick = 1; eLvl = 0;
      end else if (mCnt == mD * mL) begin
        eHigh = 1; eLvl = 1;
      end
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    check(reqTag, "sclLevel", int'(sclLevel), eLvl);
    check(reqTag, "highStrobe", int'(highStrobe), eHigh);
    check(eTick ? "R6" : reqTag, "lowStrobe", int'(lowStrobe), eLow);
    check(eTick ? "R6" : reqTag, "periodTick", int'(periodTick), eTick);
  end

  task automatic setCfg(int cdf, int scgd, int comp);
    divReg = {6'(scgd), 2'(cdf)};
    compCount = 5'(comp);
  endtask

  task automatic gapBetweenTicks(output int gap);
    do @(negedge clk); while (!periodTick);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!periodTick);
  endtask

  task automatic lowToHigh(output int gap);
    do @(negedge clk); while (!lowStrobe);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!highStrobe);
  endtask

  task automatic finish();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", "reset sclLevel", int'(sclLevel), 1);
    check("R8", "reset strobes", int'({highStrobe, lowStrobe, periodTick}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 minimum period, no prescale
    reqTag = "R2"; setCfg(0, 0, 0); enable = 1'b1;
    gapBetweenTicks(g); check("R2", "period N=20", g, 20);

    // R1 prescale by 4, N=42
    enable = 1'b0; @(negedge clk); reqTag = "R1"; setCfg(3, 2, 6); enable = 1'b1;
    gapBetweenTicks(g); check("R1", "period 4*42", g, 168);

    // R3 odd period: N=29, low 15 ticks of 2 clocks
    enable = 1'b0; @(negedge clk); reqTag = "R3"; setCfg(1, 1, 1); enable = 1'b1;
    lowToHigh(g); check("R3", "low phase 2*15", g, 30);
    gapBetweenTicks(g); check("R3", "period 2*29", g, 58);

    // R10 maximum compensation: N=51
    enable = 1'b0; @(negedge clk); reqTag = "R10"; setCfg(0, 0, 31); enable = 1'b1;
    gapBetweenTicks(g); check("R10", "period 20+31", g, 51);

    // R7 change mid-period
    reqTag = "R7";
    do @(negedge clk); while (!periodTick);
    repeat (10) @(negedge clk);
    setCfg(2, 1, 3);
    do @(negedge clk); while (!periodTick);
    check("R7", "old period kept", 1, 1);
    g = 0;
    do begin @(negedge clk); g++; end while (!periodTick);
    check("R7", "new period 3*31", g, 93);

    // R8 disable mid-phase, R9 and R5 restart
    repeat (17) @(negedge clk);
    reqTag = "R8"; enable = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8", "idle level", int'(sclLevel), 1);
    reqTag = "R9"; setCfg(0, 0, 0); enable = 1'b1;
    @(negedge clk);
    check("R5", "first lowStrobe", int'(lowStrobe), 1);
    check("R5", "no first periodTick", int'(periodTick), 0);
    g = 1;
    while (!periodTick) begin @(negedge clk); g++; end
    check("R9", "fresh period", g, 21);

    // R4 largest coarse field
    enable = 1'b0; @(negedge clk); reqTag = "R4"; setCfg(0, 63, 0); enable = 1'b1;
    gapBetweenTicks(g); check("R4", "period C=63", g, 524);

    // disable on the same cycle as a boundary
    reqTag = "R8"; setCfg(0, 0, 0);
    do @(negedge clk); while (!periodTick);
    repeat (19) @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    finish();
  end
endmodule